// File: doc/BRIEF.md
# Byte-Serial Chaining ALU

This block is an arithmetic unit with an 8-bit datapath that works on 32-bit words. Each word goes in as four bytes, least significant byte first, on four enabled cycles in a row. Four register stages sit between the operand inputs and the result output. The operation and the chain command are captured with byte 0 of each word. Every word yields four result bytes in the same order, plus three flags that describe the whole word: carry, zero and signed overflow.

A word can chain onto the word before it. When a word carries a step or end command, its A operand comes from the block's own result output. Because the pipeline depth equals the number of bytes in a word, result byte k of the previous word is on the output when byte k of the next word is taken. Operand B still comes from the input bus at full rate, so no temporary register is needed between chained operations. Only standalone words and end-of-chain words mark their bytes for writing to the bus.

A multiply-step operation builds an unsigned 8x8 product from a begin, six steps and an end. A single enable input freezes every register, so the pipeline keeps its contents while unrelated work runs.

Top module: `byte_chain_alu`

## Requirements
- R1: During and after reset, before any input byte, `out_valid`, `out_last`, `out_wr` and all three flags are 0.
- R2: A byte taken on an enabled edge with `in_valid`=1 appears on `out_byte` with `out_valid`=1 after three more enabled edges. Bytes come out in the order they went in. `out_last` marks the fourth byte of a word. `op`, `cmd` and `fill_in` are sampled only with byte 0, and their values on bytes 1 to 3 are ignored. The bytes of one word must be given on consecutive enabled cycles.
- R3: op 0 adds A+B and op 1 subtracts A-B (computed as A + ~B + 1), with the carry passed from byte to byte. Carry is the carry out of bit 31, so for subtraction carry=1 means no borrow.
- R4: op 2 gives A AND B, op 3 gives A OR B, op 4 gives A XOR B and op 7 passes B. All four set carry and overflow to 0.
- R5: op 5 shifts the 32-bit A right by one bit. Bit 31 takes the `fill_in` value captured with byte 0, and carry takes the old bit 0.
- R6: Zero is 1 only when all 32 result bits are 0. The flags change only on the enabled edge that outputs a word's last byte.
- R7: For add and subtract, overflow is the XOR of the carry into bit 31 and the carry out of bit 31. For every other op it is 0.
- R8: cmd values are 0 single, 1 begin, 2 step and 3 end. For step and end, every A byte is taken from `out_byte`, and `a_byte` is ignored. B is always taken from `b_byte`.
- R9: `out_wr` is 1 on the result bytes of single and end words and 0 on the bytes of begin and step words. It is never 1 without `out_valid`.
- R10: op 6 is a multiply step. With q = A[7:0] and t = A[7], the result is R[7:0] = q<<1 and R[31:8] = (A[31:8]<<1) + (t ? B[31:8] : 0) mod 2^24. Carry and overflow are 0. Start with A = {0, q} and B[15:8] = m, then run eight chained steps. R[23:8] ends as q*m.
- R11: While `en`=0, no register changes. Outputs, flags and the partial state of a word are all held.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| en | input | 1 | Enable for every register |
| in_valid | input | 1 | Operand byte present this cycle |
| op | input | 3 | Operation code, taken with byte 0 |
| cmd | input | 2 | Chain command, taken with byte 0 |
| fill_in | input | 1 | Bit shifted into bit 31 by op 5 |
| a_byte | input | 8 | Operand A byte |
| b_byte | input | 8 | Operand B byte |
| out_valid | output | 1 | Result byte valid |
| out_last | output | 1 | Result byte is the word's byte 3 |
| out_wr | output | 1 | Result byte is to be written to the bus |
| out_byte | output | 8 | Result byte, also the feedback operand |
| c_flag | output | 1 | Carry of the last word |
| z_flag | output | 1 | Zero of the last word |
| v_flag | output | 1 | Signed overflow of the last word |

## Verification
On every cycle, the assertions check four things. The outputs and flags stay still while the enable is low. A write mark never appears without a valid byte. The flags move only when a word's last byte leaves. Two word ends never come out on back-to-back enabled cycles. The bench scenarios are the only way to show the byte values themselves: carries and borrows crossing byte borders, the shift bit looked up from the next byte, zero detection across the whole word, feedback alignment through begin, step and end, and the eight-step multiply reaching the correct product.

// File: rtl/byte_chain_alu.sv
module byte_chain_alu (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       en,
  input  logic       in_valid,
  input  logic [2:0] op,
  input  logic [1:0] cmd,
  input  logic       fill_in,
  input  logic [7:0] a_byte,
  input  logic [7:0] b_byte,
  output logic       out_valid,
  output logic       out_last,
  output logic       out_wr,
  output logic [7:0] out_byte,
  output logic       c_flag,
  output logic       z_flag,
  output logic       v_flag
);
  localparam logic [2:0] OP_ADD = 3'd0, OP_SUB = 3'd1, OP_AND = 3'd2, OP_OR = 3'd3,
                         OP_XOR = 3'd4, OP_SHR = 3'd5, OP_MST = 3'd6, OP_PASS = 3'd7;
  localparam logic [1:0] CM_ONE = 2'd0, CM_STEP = 2'd2, CM_END = 2'd3;
  localparam int NBYTES = 4;
  localparam int IW = $clog2(NBYTES);

  logic [IW-1:0] cnt, idx1;
  logic [7:0] a1, b1;
  logic [2:0] op1;
  logic [1:0] cmd1;
  logic       v1, fill1;

  logic [1:0] cmd_now;
  logic [7:0] a_sel;
  assign cmd_now = (cnt == '0) ? cmd : cmd1;
  assign a_sel   = (cmd_now == CM_STEP || cmd_now == CM_END) ? out_byte : a_byte;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      cnt <= '0; idx1 <= '0; a1 <= '0; b1 <= '0; op1 <= '0; cmd1 <= '0; v1 <= 1'b0; fill1 <= 1'b0;
    end else if (en) begin
      v1 <= in_valid;
      if (in_valid) begin
        a1   <= a_sel;
        b1   <= b_byte;
        idx1 <= cnt;
        cnt  <= cnt + 1'b1;
        if (cnt == '0) begin
          op1 <= op; cmd1 <= cmd; fill1 <= fill_in;
        end
      end
    end

  logic       first, last, arith, ci;
  logic [7:0] pa, pb, x;
  logic [8:0] sum;
  logic       cy, sh, mb, zacc, c0;
  assign first = (idx1 == '0);
  assign last  = (idx1 == IW'(NBYTES - 1));
  assign arith = (op1 == OP_ADD) || (op1 == OP_SUB);

  always_comb begin
    pa = a1;
    pb = b1;
    ci = first ? 1'b0 : cy;
    case (op1)
      OP_SUB: begin pb = ~b1; ci = first ? 1'b1 : cy; end
      OP_MST: begin
        pa = {a1[6:0], first ? 1'b0 : sh};
        pb = (!first && mb) ? b1 : 8'h00;
      end
      default: ;
    endcase
    sum = {1'b0, pa} + {1'b0, pb} + {8'h00, ci};
    case (op1)
      OP_AND:  x = a1 & b1;
      OP_OR:   x = a1 | b1;
      OP_XOR:  x = a1 ^ b1;
      OP_SHR:  x = {last ? fill1 : a_sel[0], a1[7:1]};
      OP_PASS: x = b1;
      default: x = sum[7:0];
    endcase
  end

  logic [7:0] x2, x3;
  logic v2, last2, wr2, fc2, fz2, fv2;
  logic v3, last3, wr3, fc3, fz3, fv3;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      cy <= 1'b0; sh <= 1'b0; mb <= 1'b0; zacc <= 1'b0; c0 <= 1'b0;
      x2 <= '0; v2 <= 1'b0; last2 <= 1'b0; wr2 <= 1'b0; fc2 <= 1'b0; fz2 <= 1'b0; fv2 <= 1'b0;
    end else if (en) begin
      v2 <= v1;
      if (v1) begin
        cy    <= sum[8];
        sh    <= first ? 1'b0 : a1[7];
        mb    <= first ? a1[7] : mb;
        zacc  <= (first ? 1'b0 : zacc) | (|x);
        if (first) c0 <= a1[0];
        x2    <= x;
        last2 <= last;
        wr2   <= (cmd1 == CM_ONE) || (cmd1 == CM_END);
        fc2   <= arith ? sum[8] : ((op1 == OP_SHR) ? c0 : 1'b0);
        fz2   <= ~((first ? 1'b0 : zacc) | (|x));
        fv2   <= arith & (pa[7] ^ pb[7] ^ sum[7] ^ sum[8]);
      end
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      x3 <= '0; v3 <= 1'b0; last3 <= 1'b0; wr3 <= 1'b0; fc3 <= 1'b0; fz3 <= 1'b0; fv3 <= 1'b0;
    end else if (en) begin
      v3 <= v2; x3 <= x2; last3 <= last2; wr3 <= wr2; fc3 <= fc2; fz3 <= fz2; fv3 <= fv2;
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      out_valid <= 1'b0; out_last <= 1'b0; out_wr <= 1'b0; out_byte <= '0;
      c_flag <= 1'b0; z_flag <= 1'b0; v_flag <= 1'b0;
    end else if (en) begin
      out_valid <= v3;
      out_last  <= v3 & last3;
      out_wr    <= v3 & wr3;
      if (v3) out_byte <= x3;
      if (v3 && last3) begin
        c_flag <= fc3; z_flag <= fz3; v_flag <= fv3;
      end
    end

  AST_WR_NEEDS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    out_wr |-> out_valid); // R9
  AST_HOLD_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> $stable(out_byte) && $stable(out_valid) && $stable(out_wr) &&
            $stable({c_flag, z_flag, v_flag})); // R11
  AST_FLAGS_AT_END: assert property (@(posedge clk) disable iff (!rst_n)
    !(out_valid && out_last) |-> $stable({c_flag, z_flag, v_flag})); // R6
  AST_WORD_CADENCE: assert property (@(posedge clk) disable iff (!rst_n)
    (en && out_valid && out_last) |=> !out_last); // R2
endmodule

// File: tb/test_byte_chain_alu.sv
module test_byte_chain_alu;
  logic clk = 1'b0, rst_n = 1'b0, en = 1'b0, in_valid = 1'b0, fill_in = 1'b0;
  logic [2:0] op = '0;
  logic [1:0] cmd = '0;
  logic [7:0] a_byte = '0, b_byte = '0;
  logic out_valid, out_last, out_wr, c_flag, z_flag, v_flag;
  logic [7:0] out_byte;

  byte_chain_alu i_byte_chain_alu (
    .clk(clk), .rst_n(rst_n), .en(en), .in_valid(in_valid), .op(op), .cmd(cmd),
    .fill_in(fill_in), .a_byte(a_byte), .b_byte(b_byte), .out_valid(out_valid),
    .out_last(out_last), .out_wr(out_wr), .out_byte(out_byte),
    .c_flag(c_flag), .z_flag(z_flag), .v_flag(v_flag));

  always #5 clk = ~clk;

  int checks = 0, errors = 0;
  logic [9:0] exp_q[$];
  logic [2:0] flg_q[$];
  string tag_q[$];
  string ftag_q[$];
  logic [31:0] acc = '0;
  logic en_q = 1'b0;

  always @(posedge clk) en_q <= en;

  function automatic logic [34:0] model(input logic [2:0] o, input logic [31:0] a, b, input logic f);
    logic [32:0] s; logic [31:0] r; logic c, v;
    c = 1'b0; v = 1'b0; s = '0;
    case (o)
      3'd0: begin s = {1'b0, a} + {1'b0, b}; r = s[31:0]; c = s[32];
                  v = (a[31] == b[31]) && (r[31] != a[31]); end
      3'd1: begin s = {1'b0, a} + {1'b0, ~b} + 33'd1; r = s[31:0]; c = s[32];
                  v = (a[31] != b[31]) && (r[31] != a[31]); end
      3'd2: r = a & b;
      3'd3: r = a | b;
      3'd4: r = a ^ b;
      3'd5: begin r = {f, a[31:1]}; c = a[0]; end
      3'd6: begin r[7:0] = {a[6:0], 1'b0};
                  r[31:8] = {a[30:8], 1'b0} + (a[7] ? b[31:8] : 24'd0); end
      default: r = b;
    endcase
    return {v, (r == 32'd0), c, r};
  endfunction

  task automatic send(input logic [2:0] o, input logic [1:0] c, input logic [31:0] a, b,
                      input logic f, input string tag, input int stall_at);
    logic [31:0] aa; logic [34:0] m;
    aa = (c == 2'd2 || c == 2'd3) ? acc : a;
    m = model(o, aa, b, f);
    acc = m[31:0];
    for (int k = 0; k < 4; k++) begin
      exp_q.push_back({k == 3, (c == 2'd0 || c == 2'd3), m[8*k +: 8]});
      tag_q.push_back(tag);
    end
    flg_q.push_back(m[34:32]);
    ftag_q.push_back(tag);
    for (int k = 0; k < 4; k++) begin
      if (k == stall_at) begin
        @(negedge clk); en = 1'b0; in_valid = 1'b1; a_byte = 8'h5A; b_byte = 8'hA5; op = ~o;
      end
      @(negedge clk);
      en = 1'b1; in_valid = 1'b1;
      op = (k == 0) ? o : ~o;
      cmd = (k == 0) ? c : ~c;
      fill_in = (k == 0) ? f : ~f;
      a_byte = (c == 2'd2 || c == 2'd3) ? 8'hEE : a[8*k +: 8];
      b_byte = b[8*k +: 8];
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); en = 1'b1; in_valid = 1'b0; a_byte = 8'h00; b_byte = 8'h00;
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && en_q && out_valid && exp_q.size() > 0) begin
      logic [9:0] e; string t;
      e = exp_q.pop_front(); t = tag_q.pop_front();
      checks++;
      if (out_byte !== e[7:0] || out_wr !== e[8] || out_last !== e[9]) begin
        errors++;
        $display("FAIL %s R9 byte/wr/last got %h/%b/%b exp %h/%b/%b", t,
                 out_byte, out_wr, out_last, e[7:0], e[8], e[9]);
      end
      if (e[9]) begin
        logic [2:0] fe; string ft;
        fe = flg_q.pop_front(); ft = ftag_q.pop_front();
        checks++;
        if ({v_flag, z_flag, c_flag} !== fe) begin
          errors++;
          $display("FAIL %s R6 R7 flags vzc got %b exp %b", ft, {v_flag, z_flag, c_flag}, fe);
        end
      end
    end
  end

  task automatic finish_run;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired, expected bytes left %0d", exp_q.size());
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    checks++;
    if ({out_valid, out_last, out_wr, c_flag, z_flag, v_flag} !== 6'b0) begin
      errors++;
      $display("FAIL R1 reset outputs got %b exp 000000",
               {out_valid, out_last, out_wr, c_flag, z_flag, v_flag});
    end
    rst_n = 1'b1;
    idle(2);
    // R2 R3: plain add, then carry across every byte, then signed overflow
    send(3'd0, 2'd0, 32'h1234_5678, 32'h0101_0101, 1'b0, "R3", -1);
    send(3'd0, 2'd0, 32'hFFFF_FFFF, 32'h0000_0001, 1'b0, "R3", -1);
    send(3'd0, 2'd0, 32'h7FFF_FFFF, 32'h0000_0001, 1'b0, "R7", -1);
    idle(3);
    // R3 R7: borrow and signed overflow on subtract
    send(3'd1, 2'd0, 32'h0000_0005, 32'h0000_0007, 1'b0, "R3", -1);
    send(3'd1, 2'd0, 32'h8000_0000, 32'h0000_0001, 1'b0, "R7", -1);
    // R4: logic ops and pass
    send(3'd2, 2'd0, 32'hF0F0_1234, 32'h0FF0_FF00, 1'b0, "R4", -1);
    send(3'd3, 2'd0, 32'h1200_0034, 32'h0056_7800, 1'b0, "R4", -1);
    send(3'd4, 2'd0, 32'hAAAA_5555, 32'hAAAA_5555, 1'b0, "R4", -1);
    send(3'd7, 2'd0, 32'hDEAD_BEEF, 32'hCAFE_F00D, 1'b0, "R4", -1);
    // R6: only the low byte is nonzero, zero must stay 0
    send(3'd4, 2'd0, 32'h0000_0001, 32'h0000_0000, 1'b0, "R6", -1);
    // R5: shift right with fill 1 and fill 0
    send(3'd5, 2'd0, 32'h8001_0201, 32'h0, 1'b1, "R5", -1);
    send(3'd5, 2'd0, 32'h0100_FE00, 32'h0, 1'b0, "R5", -1);
    idle(2);
    // R11: enable dropped in the middle of words
    send(3'd0, 2'd0, 32'h00FF_FFFF, 32'h0000_0001, 1'b0, "R11", 2);
    send(3'd5, 2'd0, 32'h0300_0100, 32'h0, 1'b1, "R11", 1);
    idle(2);
    // R8 R9: begin/step/end chain, a_byte driven with junk on step/end
    send(3'd0, 2'd1, 32'h0102_0304, 32'h1010_10FF, 1'b0, "R8", -1);
    send(3'd1, 2'd2, 32'h0, 32'h0000_0105, 1'b0, "R8", -1);
    send(3'd4, 2'd3, 32'h0, 32'hFFFF_FFFF, 1'b0, "R9", -1);
    idle(3);
    // R10: eight chained multiply steps, 0xB7 * 0x5D
    send(3'd6, 2'd1, 32'h0000_00B7, 32'h0000_5D00, 1'b0, "R10", -1);
    for (int s = 0; s < 6; s++) send(3'd6, 2'd2, 32'h0, 32'h0000_5D00, 1'b0, "R10", -1);
    send(3'd6, 2'd3, 32'h0, 32'h0000_5D00, 1'b0, "R10", -1);
    idle(2);
    checks++;
    if (acc[23:8] !== 16'd17019) begin
      errors++;
      $display("FAIL R10 product got %0d exp %0d", acc[23:8], 17019);
    end
    idle(6);
    while (exp_q.size() > 0) idle(1);
    finish_run();
  end
endmodule